// File: doc/BRIEF.md
# Field-Switch PWM Duty Controller with Ramped Ceiling

This block drives the gate of a field-current switch with a fixed-frequency PWM wave. The period is 2^DUTY_W ticks of the oscillator clock (256 ticks by default), so a clock near 101 kHz gives a period rate near 395 Hz. The analog control loop supplies an 8-bit duty request. The block either passes that request straight to the output, or limits it by a digital ceiling that can only climb at a slow, pin-selected rate.

A small state machine picks the path. It has three states. **ST_START** is the start-up phase: it is entered at reset and held while `start_hold` is high. **ST_LIMIT** covers the slow and middle rotor-speed bands. **ST_DIRECT** covers the fast band. The named transitions are:
- *start_done*: ST_START to ST_LIMIT or ST_DIRECT, taken when `start_hold` is low and the ceiling has reached the request.
- *speed_up*: ST_LIMIT to ST_DIRECT.
- *speed_down*: ST_DIRECT to ST_LIMIT.
- *restart*: from any state to ST_START while `start_hold` is high.

In ST_START and ST_LIMIT the output duty is the lower of the request and the ceiling. In ST_DIRECT the ceiling simply tracks the request.

A load-dump flag forces the gate off. A new duty value takes effect only at a period boundary, so the output never carries a split or extra pulse.

Top module: `field_duty_ctrl`

## Requirements
- R1: The PWM period is exactly 256 clock ticks. A steady duty value D in 1..254 gives exactly D high ticks per period, as a single pulse.
- R2: Duty 0 keeps `gate_o` low for the whole period. Duty 255 keeps it high for the whole period, including when 255 comes from a ceiling at full scale.
- R3: The duty in use changes only at a period boundary, so at most one rising edge of `gate_o` occurs per period, even when `duty_req` changes mid-period.
- R4: The block limits the duty whenever the fast band is not indicated, that is, unless `band_high`=1 with `band_low`=`band_mid`=0. While limiting, the duty equals min(`duty_req`, ceiling).
- R5: While limiting, the ceiling rises by one LSB every N ticks, where N = OSC_HZ*10000/(256*r). The rate r in hundredths of a percent per second is selected by `rate_sel`: 00 gives 937, 01 gives 1870, 10 gives 2810 and 11 gives 3740. A pin value of 1 means the pin is open. The ceiling stops at 255.
- R6: When `duty_req` drops below the ceiling, the ceiling drops to `duty_req` on the next tick, and later ramping starts from that value.
- R7: In ST_DIRECT (fast band, start-up finished) the duty equals `duty_req` with no rate limit, and the ceiling follows `duty_req`.
- R8: The start-up phase begins at reset and is re-entered while `start_hold`=1. During it the duty is limited whatever the band. It ends at the first tick with `start_hold`=0 and ceiling >= `duty_req`.
- R9: While `load_dump`=1, `gate_o` is low from the next tick on.
- R10: After reset the ceiling and the duty in use are 0, so `gate_o` stays low for the whole first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_req | input | DUTY_W | Analog-loop duty request |
| band_low | input | 1 | Rotor speed below the lower band edge |
| band_mid | input | 1 | Rotor speed between the band edges |
| band_high | input | 1 | Rotor speed above the upper band edge |
| rate_sel | input | 2 | Ramp-rate select pins (1 = open) |
| load_dump | input | 1 | Load-dump condition, forces gate off |
| start_hold | input | 1 | Start-up qualifier, holds the rate-limited start phase |
| gate_o | output | 1 | PWM gate drive |

## Verification
A request, band or start change feeds the state register after one tick. It then waits up to 256 ticks for the next period boundary, and one more tick for the gate register. The bench therefore lets 520 ticks pass after any such change before it counts high ticks over a whole 256-tick window. The load-dump cut is due on the tick after the flag, so that window starts at once. Ramp results move by one LSB every N ticks, and the duty in use lags them by up to a period. Ramp checks therefore compare the high count against elapsed time divided by N, with a tolerance of 256/N + 3 LSB.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_LIMIT  = 2'd1,
        ST_DIRECT = 2'd2
    } fcd_state_e;

    localparam int RATE_COUNT = 4;
    localparam int SEL_W      = $clog2(RATE_COUNT);

    // ramp rate in hundredths of a percent per second
    function automatic int rate_centi(input int idx);
        case (idx)
            0:       return 937;
            1:       return 1870;
            2:       return 2810;
            default: return 3740;
        endcase
    endfunction

    // oscillator ticks per one-LSB ceiling step
    function automatic int step_ticks(input int osc_hz, input int idx, input int duty_w);
        longint num;
        longint den;
        longint q;
        num = longint'(osc_hz) * 64'sd10000;
        den = (64'sd1 <<< duty_w) * longint'(rate_centi(idx));
        q   = num / den;
        return (q < 1) ? 1 : int'(q);
    endfunction

endpackage

// File: rtl/fcd_period_counter.sv
module fcd_period_counter #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              wrap_o
);

    logic [DUTY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == '1);

    // R1: period is a full modulo-2^DUTY_W count
    a_r1_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
    a_r1_advances: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/fcd_step_timer.sv
module fcd_step_timer #(
    parameter int OSC_HZ = 101000,
    parameter int DUTY_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [fcd_pkg::SEL_W-1:0] rate_sel,
    input  logic                     restart,
    output logic                     step_o
);

    localparam int MAX_TICKS = fcd_pkg::step_ticks(OSC_HZ, 0, DUTY_W);
    localparam int TC_W      = $clog2(MAX_TICKS + 1);

    logic [TC_W-1:0] limit [fcd_pkg::RATE_COUNT];
    logic [TC_W-1:0] tc_q;
    logic            due;

    for (genvar g = 0; g < fcd_pkg::RATE_COUNT; g++) begin : g_limit
        assign limit[g] = TC_W'(fcd_pkg::step_ticks(OSC_HZ, g, DUTY_W) - 1);
    end

    assign due    = (tc_q >= limit[rate_sel]);
    assign step_o = due && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               tc_q <= '0;
        else if (restart || due)  tc_q <= '0;
        else                      tc_q <= tc_q + 1'b1;
    end

    // R5: the tick counter never runs past the slowest rate's interval
    a_r5_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (tc_q == '0));

endmodule

// File: rtl/fcd_ceiling.sv
module fcd_ceiling #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track,
    input  logic              step,
    input  logic [DUTY_W-1:0] req,
    output logic [DUTY_W-1:0] ceil_o,
    output logic              clamp_o
);

    logic [DUTY_W-1:0] ceil_q;

    assign clamp_o = !track && (req < ceil_q);
    assign ceil_o  = ceil_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ceil_q <= '0;
        else if (track || clamp_o)         ceil_q <= req;
        else if (step && (ceil_q != '1))   ceil_q <= ceil_q + 1'b1;
    end

    // R5: a ramping ceiling climbs by at most one LSB per tick
    a_r5_one_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (!track && !clamp_o) |=> (ceil_o == $past(ceil_o) || ceil_o == $past(ceil_o) + 1'b1));
    // R6: a lower request pulls the ceiling down on the next tick
    a_r6_follow_down: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |=> (ceil_o == $past(req)));

endmodule

// File: rtl/field_duty_ctrl.sv
module field_duty_ctrl #(
    parameter int OSC_HZ = 101000,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic              band_low,
    input  logic              band_mid,
    input  logic              band_high,
    input  logic [1:0]        rate_sel,
    input  logic              load_dump,
    input  logic              start_hold,
    output logic              gate_o
);

    import fcd_pkg::*;

    fcd_state_e        state_q, state_d;
    logic [DUTY_W-1:0] cnt, ceil, eff_duty, duty_q;
    logic              wrap, step, clamp, track, fast, gate_q;

    assign fast = band_high && !band_low && !band_mid;

    fcd_period_counter #(.DUTY_W(DUTY_W)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    fcd_step_timer #(.OSC_HZ(OSC_HZ), .DUTY_W(DUTY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .restart  (clamp),
        .step_o   (step)
    );

    fcd_ceiling #(.DUTY_W(DUTY_W)) u_ceiling (
        .clk     (clk),
        .rst_n   (rst_n),
        .track   (track),
        .step    (step),
        .req     (duty_req),
        .ceil_o  (ceil),
        .clamp_o (clamp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:  if (!start_hold && (ceil >= duty_req))
                           state_d = fast ? ST_DIRECT : ST_LIMIT;   // start_done
            ST_LIMIT:  if (fast)  state_d = ST_DIRECT;             // speed_up
            ST_DIRECT: if (!fast) state_d = ST_LIMIT;              // speed_down
            default:   state_d = ST_START;
        endcase
        if (start_hold) state_d = ST_START;                        // restart
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        track    = 1'b0;
        eff_duty = (duty_req < ceil) ? duty_req : ceil;
        unique case (state_q)
            ST_DIRECT: begin
                track    = 1'b1;
                eff_duty = duty_req;
            end
            default: ;
        endcase
    end

    // duty latched at the period boundary, gate registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            gate_q <= 1'b0;
        end else begin
            if (wrap) duty_q <= eff_duty;
            gate_q <= !load_dump && ((duty_q == '1) || (cnt < duty_q));
        end
    end

    assign gate_o = gate_q;

    // R3: the duty in use only moves on a period boundary
    a_r3_duty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));
    // R2: zero duty is low, full duty is high
    a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |=> !gate_o);
    a_r2_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((duty_q == '1) && !load_dump) |=> gate_o);
    // R4: limited duty never exceeds request or ceiling
    a_r4_limit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DIRECT && wrap) |=> (duty_q <= $past(duty_req) && duty_q <= $past(ceil)));
    // R7: direct state passes the request through
    a_r7_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIRECT && wrap) |=> (duty_q == $past(duty_req)));
    // R8: start qualifier holds the start phase
    a_r8_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        start_hold |=> (state_q == ST_START));
    // R9: load dump cuts the gate on the next tick
    a_r9_dump_off: assert property (@(posedge clk) disable iff (!rst_n)
        load_dump |=> !gate_o);

endmodule

// File: tb/field_duty_ctrl_tb.sv
module field_duty_ctrl_tb;

    localparam int OSC_HZ = 2560;
    localparam int DUTY_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] duty_req = '0;
    logic       band_low = 1'b0, band_mid = 1'b0, band_high = 1'b0;
    logic [1:0] rate_sel = 2'b11;
    logic       load_dump = 1'b0, start_hold = 1'b0;
    logic       gate_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    field_duty_ctrl #(.OSC_HZ(OSC_HZ), .DUTY_W(DUTY_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_req   (duty_req),
        .band_low   (band_low),
        .band_mid   (band_mid),
        .band_high  (band_high),
        .rate_sel   (rate_sel),
        .load_dump  (load_dump),
        .start_hold (start_hold),
        .gate_o     (gate_o)
    );

    // ticks per step from the rate table of R5
    function automatic int ticks_for(input int sel);
        int r;
        case (sel)
            0:       r = 937;
            1:       r = 1870;
            2:       r = 2810;
            default: r = 3740;
        endcase
        return (OSC_HZ * 10000) / (256 * r);
    endfunction

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check_rng(tag, act, exp, exp);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int highs, output int rises);
        int prev;
        prev  = gate_o;
        highs = 0;
        rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate_o) highs++;
            if (gate_o && !prev) rises++;
            prev = gate_o;
        end
    endtask

    task automatic apply_reset(input logic lo, input logic mid, input logic hi,
                               input logic [1:0] sel, input logic sh, input logic [7:0] req);
        rst_n = 1'b0;
        band_low = lo; band_mid = mid; band_high = hi;
        rate_sel = sel; start_hold = sh; duty_req = req; load_dump = 1'b0;
        wait_ticks(4);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        int h, r;
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'd200);
        measure(255, h, r);
        check_eq("R10 first period low", h, 0);
    endtask

    task automatic t_direct_path;
        int h, r;
        apply_reset(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 8'd0);
        wait_ticks(4);
        duty_req = 8'd100;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R1 high ticks for duty 100", h, 100);
        measure(1024, h, r);
        check_eq("R1 one pulse per 256 ticks", r, 4);
        duty_req = 8'd20;
        wait_ticks(520);
        duty_req = 8'd200;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R7 unlimited step to 200", h, 200);
    endtask

    task automatic t_extremes;
        int h, r;
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'd0);
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R2 duty 0 low", h, 0);
        duty_req = 8'd255;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R2 duty 255 high", h, 256);
        check_eq("R2 duty 255 no edges", r, 0);
    endtask

    task automatic t_no_glitch;
        int h, r, prev;
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'd0);
        wait_ticks(4);
        duty_req = 8'd50;
        wait_ticks(520);
        prev = gate_o;
        r = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (gate_o && !prev) r++;
            prev = gate_o;
            if (i % 37 == 36) duty_req = (duty_req == 8'd50) ? 8'd200 : 8'd50;
        end
        check_rng("R3 pulses with mid-period changes", r, 3, 4);
        h = 0;
    endtask

    task automatic t_limit_follow;
        int h, r, n;
        n = ticks_for(3);
        apply_reset(1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 8'd255);
        wait_ticks(255 * n + 600);
        measure(256, h, r);
        check_eq("R2 full ceiling high", h, 256);
        duty_req = 8'd30;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R4 min picks request", h, 30);
        duty_req = 8'd255;
        wait_ticks(520);
        measure(256, h, r);
        check_rng("R6 ramp restarts from 30", h, 30 + 520 / n - (256 / n + 3), 30 + 520 / n + 256 / n + 3);
    endtask

    task automatic t_band_low;
        int h, r, n;
        n = ticks_for(3);
        apply_reset(1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 8'd0);
        wait_ticks(4);
        duty_req = 8'd255;
        wait_ticks(1000);
        measure(256, h, r);
        check_rng("R4 low band limited", h, 1000 / n - (256 / n + 3), 1000 / n + 256 / n + 3);
    endtask

    task automatic t_startup;
        int h, r, n;
        n = ticks_for(3);
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 8'd255);
        wait_ticks(2600);
        measure(256, h, r);
        check_rng("R8 start hold limits fast band", h, 2600 / n - (256 / n + 3), 2600 / n + 256 / n + 3);
        start_hold = 1'b0;
        duty_req = 8'd60;
        wait_ticks(4);
        duty_req = 8'd250;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R8 start ends when ceiling reached", h, 250);
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'd60);
        wait_ticks(500);
        measure(256, h, r);
        check_rng("R8 start limits after reset", h, 500 / n - (256 / n + 3), 500 / n + 256 / n + 3);
        wait_ticks(1500);
        duty_req = 8'd250;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R8 direct after ramp reached request", h, 250);
    endtask

    task automatic t_rates;
        int h, r, n;
        for (int s = 0; s < 4; s++) begin
            n = ticks_for(s);
            apply_reset(1'b0, 1'b1, 1'b0, 2'(s), 1'b0, 8'd255);
            wait_ticks(2000);
            measure(256, h, r);
            check_rng($sformatf("R5 rate select %0d", s), h, 2000 / n - (256 / n + 3), 2000 / n + 256 / n + 3);
        end
    endtask

    task automatic t_load_dump;
        int h, r;
        apply_reset(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'd0);
        wait_ticks(4);
        duty_req = 8'd200;
        wait_ticks(520);
        load_dump = 1'b1;
        measure(512, h, r);
        check_eq("R9 gate off in load dump", h, 0);
        load_dump = 1'b0;
        wait_ticks(520);
        measure(256, h, r);
        check_eq("R9 gate back after load dump", h, 200);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset_state();
        t_direct_path();
        t_extremes();
        t_no_glitch();
        t_limit_follow();
        t_band_low();
        t_startup();
        t_rates();
        t_load_dump();
        report();
        $finish;
    end

endmodule